// File: doc/BRIEF.md
# Oversampling Serial Byte Receiver with Spike Filter

This block recovers bytes from an asynchronous serial line that rests high. A tick input, pulsed for one clock at eight times the bit rate, paces all of its logic. The raw line first crosses two tick-clocked flip-flops. It then passes a two-bit saturating up/down counter with hysteresis, so that short spikes never reach the framing logic. The framing logic waits for a low level on the filtered line and takes that low as a start bit. From then on it samples one bit every eight ticks: eight data bits, least significant first, and then a stop bit.

A frame is accepted only when the filtered line is high at the stop-bit boundary. When a frame is accepted, the assembled byte is presented and a ready strobe is raised for exactly one clock. The byte output is guaranteed only during that strobe. The filter delays every edge by the same number of ticks, so each sample falls at the start of its bit cell. As a result the receiver tolerates senders that run a little fast far better than senders that run slow.

Top module: `uart_os_rx`

## Requirements
- R1: After reset the ready strobe is low, and a line held high produces no strobe.
- R2: At the nominal rate of eight ticks per bit, each frame yields one strobe, and during that strobe the byte equals the frame's data. The first bit after the start bit is byte bit 0 and the eighth is bit 7.
- R3: The ready strobe is never high for two clocks in a row.
- R4: A low on an idle line that lasts for one or two tick samples never starts a frame and produces no strobe. A frame that follows such spikes is still recovered correctly.
- R5: Frames from a sender running about 1.6 % fast (7.875 ticks per bit) are all recovered, including frames sent back to back with no idle time between a stop bit and the next start bit.
- R6: A frame whose stop bit is low produces no strobe for its data. A line that is still low when the receiver returns to idle is taken as a new start bit, so a following all-high line yields a strobe carrying 8'hFF.
- R7: The receiver's state and its byte output change only at clock edges where the tick is high, and the strobe is raised only in the clock after a tick. While ticks are absent, line activity has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick8 | input | 1 | One-clock pulse at eight times the bit rate |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| rx_byte | output | DATA_BITS | Assembled byte, valid while rx_valid is high |
| rx_valid | output | 1 | One-clock strobe for an accepted frame |

## Verification
The assertions check four things on every cycle: the strobe is never wider than one clock, it appears only right after a tick, the framing state and the byte register stay frozen on clocks without a tick, and every strobe is preceded by a high filtered line. Only the bench scenarios can show the rest, because each depends on a whole sequence of line activity. These are the recovery of exact byte values in least-significant-first order, tolerance of a fast sender with back-to-back frames, rejection of one- and two-tick spikes, the dropped frame with its phantom restart, and the absence of any reaction to the line while ticks are stopped.

// File: rtl/uart_os_rx.sv
module uart_os_rx #(
  parameter int DATA_BITS = 8,
  parameter int OVS       = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick8,
  input  logic                 rx_line,
  output logic [DATA_BITS-1:0] rx_byte,
  output logic                 rx_valid
);
  localparam int SPC_W = (OVS > 1) ? $clog2(OVS) : 1;
  localparam int IDX_W = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
  localparam logic [SPC_W-1:0] SPC_LAST = SPC_W'(OVS - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_BITS - 1);

  typedef enum logic [1:0] {S_IDLE, S_DATA, S_STOP} st_t;

  logic [1:0]       sync_q;
  logic [1:0]       flt_cnt;
  logic             line_f;
  st_t              st;
  logic [SPC_W-1:0] spc;
  logic [IDX_W-1:0] idx;

  wire boundary = (spc == SPC_LAST);
  wire line_s   = sync_q[1];

  always_ff @(posedge clk)
    if (!rst_n)     sync_q <= 2'b11;
    else if (tick8) sync_q <= {sync_q[0], rx_line};

  always_ff @(posedge clk)
    if (!rst_n) begin
      flt_cnt <= 2'd3;
      line_f  <= 1'b1;
    end else if (tick8) begin
      if (line_s && flt_cnt != 2'd3)       flt_cnt <= flt_cnt + 2'd1;
      else if (!line_s && flt_cnt != 2'd0) flt_cnt <= flt_cnt - 2'd1;
      if (flt_cnt == 2'd0)      line_f <= 1'b0;
      else if (flt_cnt == 2'd3) line_f <= 1'b1;
    end

  always_ff @(posedge clk)
    if (!rst_n || st == S_IDLE) spc <= '0;
    else if (tick8)             spc <= spc + 1'b1;

  always_ff @(posedge clk)
    if (!rst_n) begin
      st      <= S_IDLE;
      idx     <= '0;
      rx_byte <= '0;
    end else if (tick8) begin
      case (st)
        S_IDLE: if (!line_f) begin
          st  <= S_DATA;
          idx <= '0;
        end
        S_DATA: if (boundary) begin
          rx_byte <= {line_f, rx_byte[DATA_BITS-1:1]};
          if (idx == IDX_LAST) st <= S_STOP;
          else                 idx <= idx + 1'b1;
        end
        S_STOP: if (boundary) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end

  always_ff @(posedge clk)
    if (!rst_n) rx_valid <= 1'b0;
    else        rx_valid <= tick8 && (st == S_STOP) && boundary && line_f;
endmodule

// File: rtl/uart_os_rx_chk.sv
module uart_os_rx_chk #(
  parameter int DATA_BITS = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 tick8,
  input logic                 rx_valid,
  input logic [DATA_BITS-1:0] rx_byte,
  input logic [1:0]           st_bits,
  input logic                 line_f
);
  a_r3_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  a_r7_valid_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(tick8));

  a_r7_byte_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !tick8 |=> $stable(rx_byte));

  a_r7_state_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !tick8 |=> $stable(st_bits));

  a_r6_stop_high: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(line_f));
endmodule

bind uart_os_rx uart_os_rx_chk #(.DATA_BITS(DATA_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick8(tick8), .rx_valid(rx_valid),
  .rx_byte(rx_byte), .st_bits(st), .line_f(line_f)
);

// File: tb/sim_uart_os_rx.sv
`timescale 1ns/1ps
module sim_uart_os_rx;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       tick8 = 0;
  logic       rx_line = 1;
  logic [7:0] rx_byte;
  logic       rx_valid;
  logic       tick_en = 1;
  logic [2:0] tdiv = 0;

  int n_cmp = 0, n_bad = 0;
  int n_got = 0, n_wide = 0;
  logic [7:0] got [0:63];
  logic prev_v = 0;
  bit done = 0;

  uart_os_rx u0 (.clk(clk), .rst_n(rst_n), .tick8(tick8), .rx_line(rx_line),
                 .rx_byte(rx_byte), .rx_valid(rx_valid));

  always #5 clk = ~clk;

  always @(negedge clk) begin
    if (!tick_en) tick8 <= 1'b0;
    else begin
      tdiv  <= tdiv + 3'd1;
      tick8 <= (tdiv == 3'd7);
    end
  end

  always @(negedge clk) begin
    if (rst_n && rx_valid) begin
      if (n_got < 64) got[n_got] = rx_byte;
      n_got = n_got + 1;
      if (prev_v) n_wide = n_wide + 1;
    end
    prev_v = rx_valid;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    rx_line = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] b, input int per, input bit stop_hi);
    rx_line = 1'b0;
    repeat (per) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx_line = b[i];
      repeat (per) @(negedge clk);
    end
    rx_line = stop_hi;
    repeat (per) @(negedge clk);
    rx_line = 1'b1;
  endtask

  task automatic t_reset;
    chk(rx_valid == 1'b0, "R1 strobe after reset", rx_valid, 0);
    idle(600);
    chk(n_got == 0, "R1 idle line frames", n_got, 0);
  endtask

  task automatic t_nominal;
    logic [7:0] pat [5] = '{8'hA5, 8'h01, 8'h80, 8'h00, 8'hFF};
    int base = n_got;
    for (int i = 0; i < 5; i++) begin
      send_frame(pat[i], 64, 1'b1);
      idle(300);
      chk(n_got == base + i + 1, "R2 frame count", n_got - base, i + 1);
      chk(got[base + i] == pat[i], "R2 byte value", got[base + i], pat[i]);
    end
    chk(n_wide == 0, "R3 strobe width", n_wide, 0);
  endtask

  task automatic t_fast;
    logic [7:0] pat [4] = '{8'h3C, 8'hC3, 8'h5A, 8'h96};
    int base = n_got;
    for (int i = 0; i < 4; i++) send_frame(pat[i], 63, 1'b1);
    idle(400);
    chk(n_got == base + 4, "R5 back-to-back count", n_got - base, 4);
    for (int i = 0; i < 4; i++)
      chk(got[base + i] == pat[i], "R5 fast byte", got[base + i], pat[i]);
  endtask

  task automatic t_glitch;
    int base = n_got;
    for (int i = 0; i < 8; i++) begin
      rx_line = 1'b0;
      repeat (8) @(negedge clk);
      idle(64);
    end
    idle(300);
    chk(n_got == base, "R4 one-tick spikes", n_got - base, 0);
    for (int i = 0; i < 8; i++) begin
      rx_line = 1'b0;
      repeat (16) @(negedge clk);
      idle(64);
    end
    idle(300);
    chk(n_got == base, "R4 two-tick spikes", n_got - base, 0);
    send_frame(8'h6E, 64, 1'b1);
    idle(300);
    chk(n_got == base + 1 && got[base] == 8'h6E, "R4 frame after spikes", got[base], 8'h6E);
  endtask

  task automatic t_bad_stop;
    int base = n_got;
    send_frame(8'h5A, 64, 1'b0);
    idle(1200);
    chk(n_got == base + 1, "R6 strobes after bad stop", n_got - base, 1);
    chk(got[base] == 8'hFF, "R6 phantom byte", got[base], 8'hFF);
    send_frame(8'h24, 64, 1'b1);
    idle(300);
    chk(got[base + 1] == 8'h24, "R6 recovery byte", got[base + 1], 8'h24);
  endtask

  task automatic t_no_tick;
    int base = n_got;
    @(negedge clk);
    tick_en = 1'b0;
    rx_line = 1'b0;
    repeat (400) @(negedge clk);
    rx_line = 1'b1;
    repeat (200) @(negedge clk);
    tick_en = 1'b1;
    idle(800);
    chk(n_got == base, "R7 line ignored without ticks", n_got - base, 0);
    send_frame(8'hC7, 64, 1'b1);
    idle(300);
    chk(got[base] == 8'hC7, "R7 frame after ticks resume", got[base], 8'hC7);
  endtask

  initial begin
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_nominal();
    t_fast();
    t_glitch();
    t_bad_stop();
    t_no_tick();
    chk(n_wide == 0, "R3 strobe width overall", n_wide, 0);
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule